// File: doc/BRIEF.md
# Sequenced Clock Source Switch Controller

This controller drives the control side of a CPU clock tree with four possible sources: a 26 MHz reference, a 32 kHz slow clock and two fast on-die oscillators. It does not contain the glitch-free multiplexer cells or the oscillators. It decides the order in which their control lines move and holds each step for the settling time the analog parts need. The outputs are a 2-bit source select, a divide-by-two select, and the enable, disable and clock-gate lines of the two fast oscillators.

Work arrives as single-cycle commands. One command picks a source directly. Suspend and resume events map to fixed sources. Two further commands power a fast oscillator path up or down. A source change writes the divider and the multiplexer in an order that keeps the CPU from seeing an over-fast clock for even one cycle. A power sequence waits a parameterized number of reference-clock cycles between its steps. While any sequence runs, the controller reports busy. A command that arrives during that time is dropped and latches an error flag. The same happens to an unknown opcode.

Top module: `clksw_top`

## Requirements
- R1: After reset, srcSel is 0 (26 MHz reference), divTwo is 0, oscAEn, oscAGate and oscBGate are 0, oscBDis is 1, and busy and cmdErr are 0.
- R2: Source codes are 0 reference, 1 slow clock, 2 second fast oscillator, 3 first fast oscillator. A select (opcode 0, code in cmdArg) to code 3 sets divTwo on the accepting edge and changes srcSel one edge later. Busy is high for exactly that one cycle.
- R3: A select to codes 0, 1 or 2 changes srcSel on the accepting edge and clears divTwo one edge later. Busy is high for exactly that one cycle.
- R4: Opcode 3 (suspend) acts as a select of code 3, and opcode 4 (resume) acts as a select of code 2, each with the ordering of R2 or R3.
- R5: Opcode 1 with cmdArg[0]=0 sets oscAEn on the accepting edge and sets oscAGate LONG_CYC cycles later. On that same edge busy falls.
- R6: Opcode 1 with cmdArg[0]=1 clears oscBDis on the accepting edge and sets oscBGate LONG_CYC cycles later. Busy falls SHORT_CYC cycles after that.
- R7: Opcode 2 with cmdArg[0]=0 clears oscAGate on the accepting edge and clears oscAEn SHORT_CYC cycles later. Busy falls after another SHORT_CYC cycles.
- R8: Opcode 2 with cmdArg[0]=1 clears oscBGate on the accepting edge and sets oscBDis SHORT_CYC cycles later. Busy falls after another SHORT_CYC cycles.
- R9: A command presented while busy is 1 changes no output except cmdErr. cmdErr becomes 1 on that edge and stays 1 until reset. This holds even on the edge where the running sequence completes.
- R10: Opcodes 5 to 7 are rejected with no output change except that cmdErr is set.
- R11: A gate is never open while its oscillator is unpowered: oscAGate implies oscAEn, and oscBGate implies not oscBDis. srcSel equal to 3 always implies divTwo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdOp | input | 3 | Opcode: 0 select, 1 power up, 2 power down, 3 suspend, 4 resume |
| cmdArg | input | 2 | Source code for select; bit 0 picks the oscillator for power commands |
| srcSel | output | 2 | Clock multiplexer select |
| divTwo | output | 1 | 1 = divide CPU clock by two, 0 = by one |
| oscAEn | output | 1 | High-clock enable of the first fast oscillator |
| oscAGate | output | 1 | Clock gate of the first fast oscillator |
| oscBDis | output | 1 | Disable switch of the second fast oscillator |
| oscBGate | output | 1 | Clock gate of the second fast oscillator |
| busy | output | 1 | A sequence is in progress |
| cmdErr | output | 1 | Sticky: a command was rejected |

## Verification
Two events can fall on the same clock edge: a running sequence completing its last step and a new command arriving. The bench provokes this by presenting a select exactly in the final busy cycle of a power-up. It expects that edge to open the gate and drop busy, leave srcSel untouched and set cmdErr. The bench then presents the same select one cycle later and expects it to be accepted. Separately, all sixteen source-to-source transitions are swept, and the intermediate state between the divider write and the multiplexer write is checked for each one.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  typedef enum logic [2:0] {
    OP_SELECT  = 3'd0,
    OP_PWRUP   = 3'd1,
    OP_PWRDN   = 3'd2,
    OP_SUSPEND = 3'd3,
    OP_RESUME  = 3'd4
  } op_e;

  localparam logic [1:0] SRC_REF   = 2'd0;
  localparam logic [1:0] SRC_FASTB = 2'd2;
  localparam logic [1:0] SRC_FASTA = 2'd3;

  typedef struct packed {
    logic       setDiv;
    logic       clrDiv;
    logic       loadSel;
    logic [1:0] selVal;
    logic       setEnA;
    logic       clrEnA;
    logic       setGateA;
    logic       clrGateA;
    logic       setDisB;
    logic       clrDisB;
    logic       setGateB;
    logic       clrGateB;
    logic       loadWait;
    logic       waitLong;
  } strobe_t;

endpackage

// File: rtl/clksw_ctl.sv
module clksw_ctl
  import clksw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic [1:0] cmdArg,
  input  logic       waitDone,
  output strobe_t    stb,
  output logic       busy,
  output logic       cmdErr
);

  typedef enum logic [1:0] {ST_IDLE, ST_SELSTEP, ST_WAIT1, ST_WAIT2} state_e;

  state_e     state, stateNxt;
  logic [1:0] tgt, tgtNxt;
  logic       oscB, oscBNxt;
  logic       powerUp, powerUpNxt;
  logic       reqTgtValid;
  logic [1:0] reqTgt;
  logic       badOp;

  assign busy = (state != ST_IDLE);

  always_comb begin
    reqTgtValid = 1'b0;
    reqTgt      = cmdArg;
    badOp       = 1'b0;
    case (cmdOp)
      OP_SELECT:  reqTgtValid = 1'b1;
      OP_SUSPEND: begin reqTgtValid = 1'b1; reqTgt = SRC_FASTA; end
      OP_RESUME:  begin reqTgtValid = 1'b1; reqTgt = SRC_FASTB; end
      OP_PWRUP, OP_PWRDN: ;
      default:    badOp = 1'b1;
    endcase
  end

  always_comb begin
    stb        = '0;
    stateNxt   = state;
    tgtNxt     = tgt;
    oscBNxt    = oscB;
    powerUpNxt = powerUp;
    case (state)
      ST_IDLE: if (cmdValid && !badOp) begin
        if (reqTgtValid) begin
          tgtNxt   = reqTgt;
          stateNxt = ST_SELSTEP;
          if (reqTgt == SRC_FASTA) stb.setDiv = 1'b1;
          else begin
            stb.loadSel = 1'b1;
            stb.selVal  = reqTgt;
          end
        end else begin
          oscBNxt      = cmdArg[0];
          powerUpNxt   = (cmdOp == OP_PWRUP);
          stateNxt     = ST_WAIT1;
          stb.loadWait = 1'b1;
          if (cmdOp == OP_PWRUP) begin
            stb.waitLong = 1'b1;
            if (cmdArg[0]) stb.clrDisB = 1'b1;
            else           stb.setEnA  = 1'b1;
          end else begin
            if (cmdArg[0]) stb.clrGateB = 1'b1;
            else           stb.clrGateA = 1'b1;
          end
        end
      end
      ST_SELSTEP: begin
        stateNxt = ST_IDLE;
        if (tgt == SRC_FASTA) begin
          stb.loadSel = 1'b1;
          stb.selVal  = tgt;
        end else begin
          stb.clrDiv = 1'b1;
        end
      end
      ST_WAIT1: if (waitDone) begin
        if (powerUp && !oscB) begin
          stb.setGateA = 1'b1;
          stateNxt     = ST_IDLE;
        end else begin
          stb.loadWait = 1'b1;
          stateNxt     = ST_WAIT2;
          if (powerUp)   stb.setGateB = 1'b1;
          else if (oscB) stb.setDisB  = 1'b1;
          else           stb.clrEnA   = 1'b1;
        end
      end
      ST_WAIT2: if (waitDone) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tgt     <= SRC_REF;
      oscB    <= 1'b0;
      powerUp <= 1'b0;
      cmdErr  <= 1'b0;
    end else begin
      state   <= stateNxt;
      tgt     <= tgtNxt;
      oscB    <= oscBNxt;
      powerUp <= powerUpNxt;
      if (cmdValid && (busy || badOp)) cmdErr <= 1'b1;
    end
  end

  // R9
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && busy) |=> cmdErr);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |=> cmdErr);

  // R2
  sel_step_short_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SELSTEP) |=> (state == ST_IDLE));

endmodule

// File: rtl/clksw_dp.sv
module clksw_dp
  import clksw_pkg::*;
#(
  parameter int LONG_CYC  = 7500,
  parameter int SHORT_CYC = 2500
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    stb,
  output logic       waitDone,
  output logic [1:0] srcSel,
  output logic       divTwo,
  output logic       oscAEn,
  output logic       oscAGate,
  output logic       oscBDis,
  output logic       oscBGate
);

  localparam int MAXCYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW     = $clog2(MAXCYC + 1);
  localparam logic [CW-1:0] LONG_LOAD  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] SHORT_LOAD = CW'(SHORT_CYC - 1);

  logic [CW-1:0] waitCnt;

  assign waitDone = (waitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waitCnt <= '0;
    else if (stb.loadWait) waitCnt <= stb.waitLong ? LONG_LOAD : SHORT_LOAD;
    else if (!waitDone) waitCnt <= waitCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSel   <= SRC_REF;
      divTwo   <= 1'b0;
      oscAEn   <= 1'b0;
      oscAGate <= 1'b0;
      oscBDis  <= 1'b1;
      oscBGate <= 1'b0;
    end else begin
      if (stb.loadSel)  srcSel   <= stb.selVal;
      if (stb.setDiv)   divTwo   <= 1'b1;
      if (stb.clrDiv)   divTwo   <= 1'b0;
      if (stb.setEnA)   oscAEn   <= 1'b1;
      if (stb.clrEnA)   oscAEn   <= 1'b0;
      if (stb.setGateA) oscAGate <= 1'b1;
      if (stb.clrGateA) oscAGate <= 1'b0;
      if (stb.setDisB)  oscBDis  <= 1'b1;
      if (stb.clrDisB)  oscBDis  <= 1'b0;
      if (stb.setGateB) oscBGate <= 1'b1;
      if (stb.clrGateB) oscBGate <= 1'b0;
    end
  end

  // R11
  fast_needs_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == SRC_FASTA) |-> divTwo);

  // R11
  gate_a_powered_chk: assert property (@(posedge clk) disable iff (!rstN)
    oscAGate |-> oscAEn);

  // R11
  gate_b_powered_chk: assert property (@(posedge clk) disable iff (!rstN)
    oscBGate |-> !oscBDis);

endmodule

// File: rtl/clksw_top.sv
module clksw_top
  import clksw_pkg::*;
#(
  parameter int LONG_CYC  = 7500,
  parameter int SHORT_CYC = 2500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic [1:0] cmdArg,
  output logic [1:0] srcSel,
  output logic       divTwo,
  output logic       oscAEn,
  output logic       oscAGate,
  output logic       oscBDis,
  output logic       oscBGate,
  output logic       busy,
  output logic       cmdErr
);

  strobe_t stb;
  logic    waitDone;

  clksw_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdArg   (cmdArg),
    .waitDone (waitDone),
    .stb      (stb),
    .busy     (busy),
    .cmdErr   (cmdErr)
  );

  clksw_dp #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .waitDone (waitDone),
    .srcSel   (srcSel),
    .divTwo   (divTwo),
    .oscAEn   (oscAEn),
    .oscAGate (oscAGate),
    .oscBDis  (oscBDis),
    .oscBGate (oscBGate)
  );

endmodule

// File: tb/sim_clksw_top.sv
module sim_clksw_top;

  localparam int L = 6;
  localparam int S = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [1:0] cmdArg = '0;
  logic [1:0] srcSel;
  logic       divTwo, oscAEn, oscAGate, oscBDis, oscBGate, busy, cmdErr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  clksw_top #(.LONG_CYC(L), .SHORT_CYC(S)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdArg(cmdArg),
    .srcSel(srcSel), .divTwo(divTwo), .oscAEn(oscAEn), .oscAGate(oscAGate),
    .oscBDis(oscBDis), .oscBGate(oscBGate), .busy(busy), .cmdErr(cmdErr)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic doReset();
    cmdValid = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic issue(input int op, input int arg);
    cmdOp = 3'(op);
    cmdArg = 2'(arg);
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    chk("R1", "srcSel", srcSel, 0);
    chk("R1", "divTwo", divTwo, 0);
    chk("R1", "oscAEn", oscAEn, 0);
    chk("R1", "oscAGate", oscAGate, 0);
    chk("R1", "oscBDis", oscBDis, 1);
    chk("R1", "oscBGate", oscBGate, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "cmdErr", cmdErr, 0);

    // R2 R3: every source-to-source transition
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        issue(0, a);
        @(negedge clk);
        issue(0, b);
        if (b == 3) begin
          chk("R2", "mid srcSel", srcSel, a);
          chk("R2", "mid divTwo", divTwo, 1);
          chk("R2", "mid busy", busy, 1);
        end else begin
          chk("R3", "mid srcSel", srcSel, b);
          chk("R3", "mid divTwo", divTwo, (a == 3) ? 1 : 0);
          chk("R3", "mid busy", busy, 1);
        end
        @(negedge clk);
        chk((b == 3) ? "R2" : "R3", "final srcSel", srcSel, b);
        chk((b == 3) ? "R2" : "R3", "final divTwo", divTwo, (b == 3) ? 1 : 0);
        chk((b == 3) ? "R2" : "R3", "final busy", busy, 0);
      end
    end

    // R4 suspend then resume
    issue(0, 0);
    @(negedge clk);
    issue(3, 0);
    chk("R4", "suspend mid srcSel", srcSel, 0);
    chk("R4", "suspend mid divTwo", divTwo, 1);
    @(negedge clk);
    chk("R4", "suspend srcSel", srcSel, 3);
    issue(4, 0);
    chk("R4", "resume mid srcSel", srcSel, 2);
    chk("R4", "resume mid divTwo", divTwo, 1);
    @(negedge clk);
    chk("R4", "resume divTwo", divTwo, 0);
    chk("R4", "resume busy", busy, 0);

    // R5 power up first oscillator
    issue(1, 0);
    for (int k = 0; k <= L + 1; k++) begin
      chk("R5", "oscAEn", oscAEn, 1);
      chk("R5", "oscAGate", oscAGate, (k >= L) ? 1 : 0);
      chk("R5", "busy", busy, (k < L) ? 1 : 0);
      @(negedge clk);
    end
    // R7 power down first oscillator
    issue(2, 0);
    for (int k = 0; k <= 2 * S + 1; k++) begin
      chk("R7", "oscAGate", oscAGate, 0);
      chk("R7", "oscAEn", oscAEn, (k < S) ? 1 : 0);
      chk("R7", "busy", busy, (k < 2 * S) ? 1 : 0);
      @(negedge clk);
    end
    // R6 power up second oscillator
    issue(1, 1);
    for (int k = 0; k <= L + S + 1; k++) begin
      chk("R6", "oscBDis", oscBDis, 0);
      chk("R6", "oscBGate", oscBGate, (k >= L) ? 1 : 0);
      chk("R6", "busy", busy, (k < L + S) ? 1 : 0);
      @(negedge clk);
    end
    // R8 power down second oscillator
    issue(2, 1);
    for (int k = 0; k <= 2 * S + 1; k++) begin
      chk("R8", "oscBGate", oscBGate, 0);
      chk("R8", "oscBDis", oscBDis, (k >= S) ? 1 : 0);
      chk("R8", "busy", busy, (k < 2 * S) ? 1 : 0);
      @(negedge clk);
    end
    chk("R9", "no error yet", cmdErr, 0);

    // R9 command in the last busy cycle of a power-up
    issue(0, 0);
    @(negedge clk);
    issue(1, 0);
    repeat (L - 1) @(negedge clk);
    chk("R9", "busy before collision", busy, 1);
    issue(0, 1);
    chk("R9", "cmdErr", cmdErr, 1);
    chk("R9", "srcSel kept", srcSel, 0);
    chk("R9", "gate opened", oscAGate, 1);
    chk("R9", "busy fell", busy, 0);
    issue(0, 1);
    chk("R9", "accepted srcSel", srcSel, 1);
    @(negedge clk);
    chk("R9", "cmdErr sticky", cmdErr, 1);

    // R10 undefined opcodes
    for (int op = 5; op < 8; op++) begin
      doReset();
      issue(op, 3);
      chk("R10", "cmdErr", cmdErr, 1);
      chk("R10", "busy", busy, 0);
      chk("R10", "srcSel", srcSel, 0);
      chk("R10", "divTwo", divTwo, 0);
      chk("R10", "oscAEn", oscAEn, 0);
      chk("R10", "oscBDis", oscBDis, 1);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule